// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block takes a serial bit stream that has already been recovered from the line, one bit per cycle in which a bit enable is high. It finds the 12-bit word boundary. Each word on the line carries a start bit of 1, ten payload bits and a stop bit of 0. The fixed 1/0 pair that every word carries works as an embedded clock marker.

Before lock, the block tests one candidate boundary position at a time. If the marker is missing at that position, the candidate moves on by one bit. Once enough consecutive words have confirmed the position, the active-low lock flag drops. From then on, each received word is presented on a 10-bit parallel output together with a one-cycle strobe. Repeated misses while locked cause the lock to be given up and the search to start again. The search works on the repeated six-ones/six-zeros sync pattern and also on ordinary framed data.

Top module: `frame_lock_det`

## Requirements
- R1: Within a word, the first payload bit received after the start bit appears on `data_out[0]` and the last one appears on `data_out[9]`. A word is valid when its first bit is 1 and its twelfth bit is 0.
- R2: After reset, `lock_n` is 1, `word_vld` is 0 and `data_out` is zero. While `lock_n` is 1, `data_out` stays zero and `word_vld` stays 0.
- R3: The search starts only after the first change of `ser_in` between enabled bits. The level before the first bit after reset counts as 0. A constant-0 stream never advances the search, and it leaves the phase where it was at reset.
- R4: Lock is declared on the last bit of the 8th consecutive word whose candidate boundary shows a stop bit of 0 and a start bit of 1. When a sync pattern is aligned from the first bit after reset, `lock_n` falls on the 96th bit.
- R5: When the candidate boundary fails during search, the candidate moves on by one bit and the count of good words restarts. A sync stream that starts three bits into its run of ones locks on the 105th bit.
- R6: On the repeated pattern of six 1s followed by six 0s, alignment settles at the single 0-to-1 transition, and the delivered word is 10'h01F.
- R7: The block locks onto framed non-repeating payload data that begins at an arbitrary bit offset, and it then delivers every word unchanged.
- R8: While locked, up to 3 consecutive boundary violations keep lock, and those words are still delivered. A good word clears the violation count. On the 4th consecutive violation, `lock_n` rises, no strobe is given, and `data_out` returns to zero.
- R9: While locked, `word_vld` is high for exactly one clock cycle per word, in the cycle after the word's last bit is taken. Cycles with `bit_en` low take no bit and never raise `word_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High when `ser_in` holds a new bit |
| ser_in | input | 1 | Recovered serial bit |
| lock_n | output | 1 | Low while word alignment is held |
| data_out | output | 10 | Payload of the last delivered word, zero while unlocked |
| word_vld | output | 1 | One-cycle strobe per delivered word |

## Verification
The embedded assertions check several properties on every cycle. They check that the strobe and non-zero data never appear while unlocked, and that a strobe never follows a cycle without a bit. They also check that lock cannot exist before an input transition, that the violation counter stays below its limit, and that lock only falls or rises together with the matching strobe behaviour. The exact lock latency, the one-bit slip during search, the payload bit order and the unique alignment on the sync pattern depend on whole sequences of input, so only the bench scenarios can show them. The same holds for the three-miss tolerance followed by loss on the fourth miss.

// File: rtl/frame_lock_det.sv
module frame_lock_det #(
  parameter int FRAME_W     = 12,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               ser_in,
  output logic               lock_n,
  output logic [FRAME_W-3:0] data_out,
  output logic               word_vld
);

  localparam int PW   = FRAME_W - 2;
  localparam int PH_W = $clog2(FRAME_W);
  localparam int GC_W = $clog2(LOCK_FRAMES + 1);
  localparam int MC_W = $clog2(LOSS_FRAMES + 1);

  logic [FRAME_W-2:0] sr;
  logic               prev, act, locked;
  logic [PH_W-1:0]    ph;
  logic [GC_W-1:0]    good;
  logic [MC_W-1:0]    miss;
  logic [PW-1:0]      pay;

  wire [FRAME_W-1:0] win  = {sr, ser_in};
  wire               live = act | (ser_in != prev);
  wire               bnd  = bit_en && live && (ph == PH_W'(FRAME_W - 1));
  wire               ok   = win[FRAME_W-1] & ~win[0];
  wire               acq  = !locked && ok && (good == GC_W'(LOCK_FRAMES - 1));
  wire               drop = locked && !ok && (miss == MC_W'(LOSS_FRAMES - 1));
  wire               keep = (locked && !drop) || acq;

  always_comb
    for (int i = 0; i < PW; i++) pay[i] = win[FRAME_W-2-i];

  assign lock_n = ~locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      prev     <= 1'b0;
      act      <= 1'b0;
      ph       <= '0;
      good     <= '0;
      miss     <= '0;
      locked   <= 1'b0;
      data_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_en) begin
        sr   <= win[FRAME_W-2:0];
        prev <= ser_in;
        act  <= live;
        if (live && !bnd) ph <= ph + 1'b1;
        if (bnd) begin
          word_vld <= keep;
          data_out <= keep ? pay : '0;
          if (locked || ok) ph <= '0;
          if (locked) begin
            if (ok) miss <= '0;
            else if (drop) begin
              locked <= 1'b0;
              miss   <= '0;
              good   <= '0;
            end else miss <= miss + 1'b1;
          end else if (ok) begin
            if (acq) begin
              locked <= 1'b1;
              good   <= '0;
            end else good <= good + 1'b1;
          end else good <= '0;
        end
      end
    end
  end

  assert_vld_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> !lock_n);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n |-> (data_out == '0));
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !word_vld);
  assert_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> lock_n);
  assert_miss_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss < MC_W'(LOSS_FRAMES));
  assert_lock_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> word_vld);
  assert_lock_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> !word_vld);

endmodule

// File: tb/test_frame_lock_det.sv
module test_frame_lock_det;
  logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, ser_in = 1'b0;
  logic       lock_n, word_vld;
  logic [9:0] data_out;
  int checks = 0, errors = 0, cyc = 0;
  int fr_vld, gap_bad;
  logic       last_vld;
  logic [9:0] fr_data;
  logic [15:0] lfsr;

  frame_lock_det i_frame_lock_det (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .lock_n(lock_n), .data_out(data_out), .word_vld(word_vld));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b, input bit gap);
    ser_in = b; bit_en = 1'b1;
    @(posedge clk); @(negedge clk);
    last_vld = word_vld;
    if (word_vld) begin fr_vld++; fr_data = data_out; end
    if (gap) begin
      bit_en = 1'b0; ser_in = ~b;
      @(posedge clk); @(negedge clk);
      if (word_vld) gap_bad++;
    end
  endtask

  task automatic send_frame(input logic st, input logic [9:0] pay, input logic sp, input bit gap);
    fr_vld = 0;
    send_bit(st, gap);
    for (int i = 0; i < 10; i++) send_bit(pay[i], gap && (i % 3 == 0));
    send_bit(sp, gap);
  endtask

  task automatic t_reset();
    do_reset();
    check(lock_n === 1'b1, "R2 reset lock_n", lock_n, 1);
    check(word_vld === 1'b0, "R2 reset word_vld", word_vld, 0);
    check(data_out === 10'h0, "R2 reset data_out", data_out, 0);
  endtask

  task automatic t_sync_aligned();
    do_reset();
    for (int i = 0; i < 96; i++) begin
      send_bit(i % 12 < 6, 1'b0);
      if (i == 94) check(lock_n === 1'b1, "R4 still searching at bit 95", lock_n, 1);
      if (i == 94) check(data_out === 10'h0, "R2 data held before lock", data_out, 0);
    end
    check(lock_n === 1'b0, "R4 lock on bit 96", lock_n, 0);
    check(last_vld === 1'b1, "R9 strobe with lock", last_vld, 1);
    check(data_out === 10'h01F, "R6 sync word", data_out, 10'h01F);
  endtask

  task automatic t_idle();
    do_reset();
    fr_vld = 0;
    for (int i = 0; i < 200; i++) send_bit(1'b0, 1'b0);
    check(lock_n === 1'b1 && fr_vld == 0, "R3 constant zero gives no lock", lock_n, 1);
    for (int i = 0; i < 96; i++) begin
      send_bit(i % 12 < 6, 1'b0);
      if (i == 94) check(lock_n === 1'b1, "R3 phase untouched, bit 95", lock_n, 1);
    end
    check(lock_n === 1'b0, "R3 phase untouched, lock on bit 96", lock_n, 0);
  endtask

  task automatic t_slip();
    do_reset();
    for (int i = 0; i < 105; i++) begin
      send_bit((i + 3) % 12 < 6, 1'b0);
      if (i == 103) check(lock_n === 1'b1, "R5 no lock at bit 104", lock_n, 1);
    end
    check(lock_n === 1'b0, "R5 lock at bit 105", lock_n, 0);
    check(data_out === 10'h01F, "R6 unique alignment", data_out, 10'h01F);
  endtask

  task automatic t_payload();
    logic [9:0] pats [3] = '{10'h001, 10'h200, 10'h2A5};
    do_reset();
    for (int f = 0; f < 8; f++) send_frame(1'b1, 10'h01F, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      send_frame(1'b1, pats[k], 1'b0, 1'b0);
      check(fr_vld == 1 && last_vld, "R9 one strobe at word end", fr_vld, 1);
      check(fr_data === pats[k], "R1 payload bit order", fr_data, pats[k]);
    end
  endtask

  task automatic t_random();
    int lock_at = -1;
    logic [9:0] p;
    do_reset();
    lfsr = 16'hACE1; gap_bad = 0;
    send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    for (int f = 0; f < 45; f++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr[9:0];
      send_frame(1'b1, p, 1'b0, 1'b1);
      if (lock_at >= 0) begin
        check(fr_vld == 1 && last_vld, "R9 strobe per word with gaps", fr_vld, 1);
        check(fr_data === p, "R7 random word delivered", fr_data, p);
      end
      if (lock_at < 0 && lock_n === 1'b0) lock_at = f;
    end
    check(lock_at >= 0 && lock_at <= 30, "R7 lock on random data", lock_at, 30);
    check(gap_bad == 0, "R9 no strobe in idle cycles", gap_bad, 0);
  endtask

  task automatic t_loss();
    do_reset();
    for (int f = 0; f < 8; f++) send_frame(1'b1, 10'h01F, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      send_frame(1'b1, 10'h155, 1'b1, 1'b0);
      check(lock_n === 1'b0 && last_vld && fr_data === 10'h155, "R8 miss tolerated", lock_n, 0);
    end
    send_frame(1'b1, 10'h0F0, 1'b0, 1'b0);
    check(lock_n === 1'b0 && fr_data === 10'h0F0, "R8 good word clears misses", fr_data, 10'h0F0);
    for (int k = 0; k < 3; k++) send_frame(1'b1, 10'h155, 1'b1, 1'b0);
    check(lock_n === 1'b0, "R8 three misses after clear keep lock", lock_n, 0);
    send_frame(1'b1, 10'h155, 1'b1, 1'b0);
    check(lock_n === 1'b1, "R8 fourth miss drops lock", lock_n, 1);
    check(fr_vld == 0, "R8 no strobe on dropping word", fr_vld, 0);
    check(data_out === 10'h0, "R2 data cleared after loss", data_out, 0);
  endtask

  initial begin
    t_reset();
    t_sync_aligned();
    t_idle();
    t_slip();
    t_payload();
    t_random();
    t_loss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule